// File: doc/BRIEF.md
# Memory Address and Data Register Port

This block sits between the internal buses of a small byte-oriented CPU datapath and an external byte-wide memory on a system bus. It holds a 16-bit address register made of two byte halves and an 8-bit data register. A single address strobe captures the high byte from the A bus and the low byte from the B bus together. One strobe loads the whole address.

The data register is fed by a two-input selector. A select value of 0 takes the byte arriving from the system bus. A select value of 1 takes the result path from the C selector, which is how a CPU register value is prepared for a store. The register's value is always presented to the A-side selector of the datapath.

Read and write requests are registered into memory enables. While the write enable is high, the data register drives the write data. Requesting a read and a write in the same cycle is illegal. In that case the block raises an error flag and performs neither transfer.

Top module: `memif_bus_port`

## Requirements
- R1: A synchronous active-high reset clears the address, the data register, both memory enables, the write data and the error flag to zero.
- R2: When the address strobe is high at a clock edge, the address becomes {A bus, B bus}, with the A bus in bits 15:8 and the B bus in bits 7:0.
- R3: When the address strobe is low, the address keeps its value.
- R4: When the data strobe is high and the source select is 0, the data register loads the system-bus read byte at that edge. The data register output shows this value.
- R5: When the data strobe is high and the source select is 1, the data register loads the C-selector result byte at that edge.
- R6: When the data strobe is low, the data register keeps its value whatever the select and the data inputs do.
- R7: A read request without a write request in a cycle makes the read enable high and the write enable low after the next edge.
- R8: A write request without a read request makes the write enable high after the next edge. While the write enable is high, the write data equals the data register. At all other times the write data is zero.
- R9: When the read and write requests are both high, after the next edge the error flag is high and both enables are low. In every other case the error flag is low after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_bus | input | 8 | A bus byte, source of the address high half |
| b_bus | input | 8 | B bus byte, source of the address low half |
| c_result | input | 8 | C-selector output byte |
| sys_rd_data | input | 8 | Byte read from the system bus |
| addr_ld | input | 1 | Address register load strobe |
| data_ld | input | 1 | Data register load strobe |
| data_src_sel | input | 1 | Data source select: 0 system bus, 1 C result |
| rd_req | input | 1 | Memory read request |
| wr_req | input | 1 | Memory write request |
| mem_addr | output | 16 | Address to the system bus |
| mem_wr_data | output | 8 | Write data, gated by the write enable |
| mem_rd_en | output | 1 | Registered read enable |
| mem_wr_en | output | 1 | Registered write enable |
| data_q | output | 8 | Data register value toward the A-side selector |
| xfer_err | output | 1 | Registered read and write conflict flag |

## Verification
The bench builds the block with its defaults: a byte width of 8 and two address parts, which gives a 16-bit address. With these values, random bytes on every bus reach both halves and the extreme patterns 0x00 and 0xFF, so a swapped or shifted half shows up. Random strobes, selects and requests cover every mix of load, hold, read, write and conflict in consecutive cycles. This includes a write issued on the same edge that reloads the data register, and a reset applied in the middle of traffic.

// File: rtl/memif_pkg.sv
package memif_pkg;
  localparam int DEF_BYTE_W = 8;
  localparam int DEF_ADDR_PARTS = 2;

  typedef enum logic {
    SRC_SYSBUS = 1'b0,
    SRC_RESULT = 1'b1
  } data_src_e;
endpackage

// File: rtl/memif_addr_reg.sv
module memif_addr_reg #(
  parameter int BYTE_W  = memif_pkg::DEF_BYTE_W,
  parameter int N_PARTS = memif_pkg::DEF_ADDR_PARTS,
  localparam int ADDR_W = BYTE_W * N_PARTS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [ADDR_W-1:0] parts_in,
  output logic [ADDR_W-1:0] addr_q
);
  for (genvar g = 0; g < N_PARTS; g++) begin : g_part
    always_ff @(posedge clk) begin
      if (rst) addr_q[g*BYTE_W +: BYTE_W] <= '0;
      else if (ld) addr_q[g*BYTE_W +: BYTE_W] <= parts_in[g*BYTE_W +: BYTE_W];
    end
  end

  // R2: a strobe captures all parts at once
  p_addr_load_r2: assert property (@(posedge clk) disable iff (rst)
    ld |=> addr_q == $past(parts_in));
  // R3: no strobe, no change
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !ld |=> $stable(addr_q));
endmodule

// File: rtl/memif_data_reg.sv
module memif_data_reg
  import memif_pkg::*;
#(
  parameter int BYTE_W = DEF_BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  data_src_e         src,
  input  logic [BYTE_W-1:0] sys_in,
  input  logic [BYTE_W-1:0] res_in,
  output logic [BYTE_W-1:0] q
);
  logic [BYTE_W-1:0] mux_out;

  always_comb begin
    mux_out = (src == SRC_RESULT) ? res_in : sys_in;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (ld) q <= mux_out;
  end

  // R4
  p_data_sys_r4: assert property (@(posedge clk) disable iff (rst)
    (ld && src == SRC_SYSBUS) |=> q == $past(sys_in));
  // R5
  p_data_res_r5: assert property (@(posedge clk) disable iff (rst)
    (ld && src == SRC_RESULT) |=> q == $past(res_in));
  // R6
  p_data_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !ld |=> $stable(q));
endmodule

// File: rtl/memif_xfer_ctl.sv
module memif_xfer_ctl (
  input  logic clk,
  input  logic rst,
  input  logic rd_req,
  input  logic wr_req,
  output logic rd_en,
  output logic wr_en,
  output logic err
);
  logic clash;

  always_comb begin
    clash = rd_req && wr_req;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_en <= 1'b0;
      wr_en <= 1'b0;
      err   <= 1'b0;
    end else begin
      rd_en <= rd_req && !clash;
      wr_en <= wr_req && !clash;
      err   <= clash;
    end
  end

  // R7
  p_rd_only_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !wr_req) |=> (rd_en && !wr_en && !err));
  // R9
  p_clash_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_req && wr_req) |=> (err && !rd_en && !wr_en));
  p_excl_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_en, wr_en, err}));
endmodule

// File: rtl/memif_bus_port.sv
module memif_bus_port
  import memif_pkg::*;
#(
  parameter int BYTE_W = DEF_BYTE_W,
  localparam int ADDR_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] a_bus,
  input  logic [BYTE_W-1:0] b_bus,
  input  logic [BYTE_W-1:0] c_result,
  input  logic [BYTE_W-1:0] sys_rd_data,
  input  logic              addr_ld,
  input  logic              data_ld,
  input  logic              data_src_sel,
  input  logic              rd_req,
  input  logic              wr_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wr_data,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [BYTE_W-1:0] data_q,
  output logic              xfer_err
);
  data_src_e src;

  always_comb begin
    src = data_src_e'(data_src_sel);
  end

  memif_addr_reg #(.BYTE_W(BYTE_W), .N_PARTS(2)) u_addr (
    .clk      (clk),
    .rst      (rst),
    .ld       (addr_ld),
    .parts_in ({a_bus, b_bus}),
    .addr_q   (mem_addr)
  );

  memif_data_reg #(.BYTE_W(BYTE_W)) u_data (
    .clk    (clk),
    .rst    (rst),
    .ld     (data_ld),
    .src    (src),
    .sys_in (sys_rd_data),
    .res_in (c_result),
    .q      (data_q)
  );

  memif_xfer_ctl u_ctl (
    .clk    (clk),
    .rst    (rst),
    .rd_req (rd_req),
    .wr_req (wr_req),
    .rd_en  (mem_rd_en),
    .wr_en  (mem_wr_en),
    .err    (xfer_err)
  );

  always_comb begin
    mem_wr_data = mem_wr_en ? data_q : '0;
  end

  // R8
  p_wr_only_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !rd_req) |=> (mem_wr_en && mem_wr_data == data_q));
  p_wr_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !mem_wr_en |-> mem_wr_data == '0);
  // R1
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (mem_addr == '0 && data_q == '0 && !mem_rd_en && !mem_wr_en && !xfer_err));
endmodule

// File: tb/memif_bus_port_tb.sv
`timescale 1ns/1ps
module memif_bus_port_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] a_bus = '0, b_bus = '0, c_result = '0, sys_rd_data = '0;
  logic addr_ld = 1'b0, data_ld = 1'b0, data_src_sel = 1'b0, rd_req = 1'b0, wr_req = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0] mem_wr_data, data_q;
  logic mem_rd_en, mem_wr_en, xfer_err;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [15:0] e_addr = '0;
  logic [7:0]  e_data = '0;
  logic e_rd = 1'b0, e_wr = 1'b0, e_err = 1'b0;

  always #5 clk = ~clk;

  memif_bus_port u_dut (
    .clk(clk), .rst(rst), .a_bus(a_bus), .b_bus(b_bus), .c_result(c_result),
    .sys_rd_data(sys_rd_data), .addr_ld(addr_ld), .data_ld(data_ld),
    .data_src_sel(data_src_sel), .rd_req(rd_req), .wr_req(wr_req),
    .mem_addr(mem_addr), .mem_wr_data(mem_wr_data), .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en), .data_q(data_q), .xfer_err(xfer_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] wdata_exp(input logic wr, input logic [7:0] d);
    return wr ? d : 8'h00;
  endfunction

  // drive one cycle at a negedge, predict, and check at the next negedge
  task automatic step(input logic r, input logic [7:0] a, input logic [7:0] b,
                      input logic [7:0] c, input logic [7:0] s, input logic al,
                      input logic dl, input logic sel, input logic rq, input logic wq);
    string ta, td, tc;
    rst = r; a_bus = a; b_bus = b; c_result = c; sys_rd_data = s;
    addr_ld = al; data_ld = dl; data_src_sel = sel; rd_req = rq; wr_req = wq;
    if (r) begin
      e_addr = '0; e_data = '0; e_rd = 0; e_wr = 0; e_err = 0;
      ta = "R1"; td = "R1"; tc = "R1";
    end else begin
      ta = al ? "R2" : "R3";
      if (al) e_addr = {a, b};
      td = !dl ? "R6" : (sel ? "R5" : "R4");
      if (dl) e_data = sel ? c : s;
      e_rd = rq && !wq; e_wr = wq && !rq; e_err = rq && wq;
      tc = e_err ? "R9" : (e_wr ? "R8" : (e_rd ? "R7" : "R9"));
    end
    @(negedge clk);
    chk(ta, mem_addr, e_addr);
    chk(td, data_q, e_data);
    chk(tc, mem_rd_en, e_rd);
    chk(tc, mem_wr_en, e_wr);
    chk(tc, xfer_err, e_err);
    chk(r ? "R1" : "R8", mem_wr_data, wdata_exp(e_wr, e_data));
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    chk("R1", mem_addr, 0); chk("R1", data_q, 0); chk("R1", mem_rd_en, 0);
    chk("R1", mem_wr_en, 0); chk("R1", xfer_err, 0); chk("R1", mem_wr_data, 0);
    // directed corners
    step(0, 8'hFF, 8'h00, 8'h00, 8'h00, 1, 0, 0, 0, 0); // R2 high half only
    step(0, 8'h00, 8'hFF, 8'h00, 8'h00, 1, 0, 0, 0, 0); // R2 low half only
    step(0, 8'h12, 8'h34, 8'h00, 8'h00, 0, 0, 1, 0, 0); // R3 hold
    step(0, 8'h00, 8'h00, 8'hAA, 8'h55, 0, 1, 0, 1, 0); // R4 + R7
    step(0, 8'h00, 8'h00, 8'hAA, 8'h55, 0, 1, 1, 0, 1); // R5 + R8 same edge
    step(0, 8'h00, 8'h00, 8'h11, 8'h22, 0, 0, 0, 1, 1); // R6 + R9
    step(0, 8'h00, 8'h00, 8'h00, 8'h00, 0, 0, 1, 0, 1); // R8 write again
    step(1, 8'h77, 8'h77, 8'h77, 8'h77, 1, 1, 1, 0, 1); // R1 mid-run reset
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 200) == 0, 8'($urandom), 8'($urandom), 8'($urandom),
           8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom));
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule